// File: doc/BRIEF.md
# Paged Program-Memory Table Reader

This block serves the table-lookup instructions of a small microcontroller. Software loads an 8-bit offset register and an 8-bit page register. It then issues a lookup command that names a data-memory destination. The block reads one 16-bit word from program memory. The low byte of that word goes to the data-memory write port at the destination. The high byte goes into a dedicated latch that software can read but not write.

A lookup takes its page either from the page register or from a fixed last page (9FH by default). This lets constant tables at the top of the code space be reached without disturbing the page register.

Every lookup takes two cycles. In the first cycle the block stalls the core and presents the word address to a synchronous program-memory port. In the second cycle it takes the returned word and performs both writes. A command that arrives while a lookup is in flight is dropped.

Top module: `pgtbl_reader`

## Requirements
- R1: The low 8 bits of the program-memory address equal the offset register value at the clock edge that accepts the command.
- R2: For a command with `cmdLast`=0, the upper 8 address bits equal the page register value at the accepting edge.
- R3: For a command with `cmdLast`=1, the upper 8 address bits are the constant `LAST_PAGE` (binary 10011111, 9FH), whatever the page register holds.
- R4: In the second cycle of a lookup, `dmWrEn` is high for exactly one cycle. `dmWrAddr` equals the `cmdDest` sampled at acceptance, and `dmWrData` equals bits [7:0] of the fetched word.
- R5: At the end of the second cycle, bits [15:8] of the fetched word are loaded into the high-byte latch. Software reads the latch with `regRdSel`=2.
- R6: The offset register is written with `regWrSel`=0 and the page register with `regWrSel`=1, both when `regWrEn`=1. `regRdSel`=0 reads the offset register and `regRdSel`=1 reads the page register, combinationally.
- R7: The high-byte latch changes only on a lookup's second cycle. Register writes of either kind leave it unchanged.
- R8: After the accepting edge, the next cycle has `stall`=1, `pmRdEn`=1 and a valid `pmAddr`. The cycle after that has `stall`=0 and `dmWrEn`=1. The block is idle in the cycle after that.
- R9: `busy` is high during both lookup cycles. A `cmdValid` seen while `busy` is high is ignored: it causes no extra program-memory read and no extra data-memory write.
- R10: After reset, both registers and the latch read 0. `busy`, `stall`, `pmRdEn` and `dmWrEn` are 0.
- R11: Register writes made while a lookup is in flight do not alter that lookup's address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 0 offset, 1 page |
| regWrData | input | 8 | Register write data |
| regRdSel | input | 2 | Read select: 0 offset, 1 page, 2 high-byte latch, 3 reads 0 |
| regRdData | output | 8 | Register read data |
| cmdValid | input | 1 | Lookup command strobe |
| cmdLast | input | 1 | 1 selects the fixed last page, 0 the page register |
| cmdDest | input | 8 | Data-memory destination address |
| pmRdEn | output | 1 | Program-memory read enable |
| pmAddr | output | 16 | Program-memory word address |
| pmData | input | 16 | Program-memory read data, valid the cycle after `pmRdEn` |
| dmWrEn | output | 1 | Data-memory write enable |
| dmWrAddr | output | 8 | Data-memory write address |
| dmWrData | output | 8 | Data-memory write data (low byte of the word) |
| stall | output | 1 | Core stall during the fetch cycle |
| busy | output | 1 | Lookup in progress |

## Verification
The embedded properties assume a program memory with exactly one cycle of read latency. They also assume that `pmData` is meaningful only in the cycle after a read strobe. The bench models the memory as a registered function of the address, so every fetched word is known from its address alone.

Stimulus changes inputs on the falling clock edge only. It holds `cmdValid` high into busy cycles only in the directed cases that exercise R9. It makes register writes during a lookup only in the case aimed at R11.

// File: rtl/pgtbl_pkg.sv
package pgtbl_pkg;

  // Strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic captureAddr;  // latch address and destination for a new lookup
    logic selLast;      // use the fixed last page instead of the page register
    logic issueRead;    // fetch cycle: drive the program-memory read
    logic commitWrite;  // write cycle: data-memory write and latch load
  } tblStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } tblState_t;

  localparam logic [1:0] RD_OFFSET = 2'd0;
  localparam logic [1:0] RD_PAGE   = 2'd1;
  localparam logic [1:0] RD_HIGH   = 2'd2;

  localparam logic WR_OFFSET = 1'b0;
  localparam logic WR_PAGE   = 1'b1;

endpackage

// File: rtl/pgtbl_ctrl.sv
module pgtbl_ctrl
  import pgtbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdLast,
  output tblStrobe_t stb,
  output logic       busy,
  output logic       stall
);

  tblState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_FETCH;
      ST_FETCH: stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.captureAddr = (state == ST_IDLE) && cmdValid;
    stb.selLast     = cmdLast;
    stb.issueRead   = (state == ST_FETCH);
    stb.commitWrite = (state == ST_WRITE);
  end

  assign busy  = (state != ST_IDLE);
  assign stall = (state == ST_FETCH);

  // R8: acceptance leads to a stalled fetch cycle
  a_r8_accept_then_fetch: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureAddr |=> (stall && busy && stb.issueRead));

  // R8: fetch is followed by a non-stalled write cycle
  a_r8_fetch_then_write: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (busy && !stall && stb.commitWrite));

  // R9: a command seen in the write cycle is not taken
  a_r9_drop_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stall && cmdValid) |=> !busy);

  // R8: fetch and write strobes never overlap
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.issueRead, stb.commitWrite}));

endmodule

// File: rtl/pgtbl_dp.sv
module pgtbl_dp
  import pgtbl_pkg::*;
#(
  parameter int          PTR_W     = 8,
  parameter int          DM_AW     = 8,
  parameter logic [7:0]  LAST_PAGE = 8'h9F,
  localparam int         ADDR_W    = 2 * PTR_W,
  localparam int         WORD_W    = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        stb,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [PTR_W-1:0]  regWrData,
  input  logic [1:0]        regRdSel,
  output logic [PTR_W-1:0]  regRdData,
  input  logic [DM_AW-1:0]  cmdDest,
  output logic              pmRdEn,
  output logic [ADDR_W-1:0] pmAddr,
  input  logic [WORD_W-1:0] pmData,
  output logic              dmWrEn,
  output logic [DM_AW-1:0]  dmWrAddr,
  output logic [PTR_W-1:0]  dmWrData
);

  logic [PTR_W-1:0]  offsetReg;
  logic [PTR_W-1:0]  pageReg;
  logic [PTR_W-1:0]  highLatch;
  logic [ADDR_W-1:0] addrQ;
  logic [DM_AW-1:0]  destQ;
  logic [PTR_W-1:0]  pageSel;

  // Software-visible pointer registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetReg <= '0;
      pageReg   <= '0;
    end else if (regWrEn) begin
      if (regWrSel == WR_OFFSET) offsetReg <= regWrData;
      else                       pageReg   <= regWrData;
    end
  end

  // Page source: fixed last page or page register
  assign pageSel = stb.selLast ? PTR_W'(LAST_PAGE) : pageReg;

  // Address and destination are frozen at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      destQ <= '0;
    end else if (stb.captureAddr) begin
      addrQ <= {pageSel, offsetReg};
      destQ <= cmdDest;
    end
  end

  // High-byte latch: loaded only by a lookup
  always_ff @(posedge clk) begin
    if (!rstN)                highLatch <= '0;
    else if (stb.commitWrite) highLatch <= pmData[WORD_W-1:PTR_W];
  end

  assign pmRdEn   = stb.issueRead;
  assign pmAddr   = addrQ;
  assign dmWrEn   = stb.commitWrite;
  assign dmWrAddr = destQ;
  assign dmWrData = pmData[PTR_W-1:0];

  always_comb begin
    unique case (regRdSel)
      RD_OFFSET: regRdData = offsetReg;
      RD_PAGE:   regRdData = pageReg;
      RD_HIGH:   regRdData = highLatch;
      default:   regRdData = '0;
    endcase
  end

  // R1: low address byte comes from the offset register at acceptance
  a_r1_offset_addr: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureAddr |=> (pmAddr[PTR_W-1:0] == $past(offsetReg)));

  // R2: current-page lookups use the page register
  a_r2_page_addr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.captureAddr && !stb.selLast) |=> (pmAddr[ADDR_W-1:PTR_W] == $past(pageReg)));

  // R3: last-page lookups use the fixed page
  a_r3_last_page: assert property (@(posedge clk) disable iff (!rstN)
    (stb.captureAddr && stb.selLast) |=> (pmAddr[ADDR_W-1:PTR_W] == PTR_W'(LAST_PAGE)));

  // R4: the data-memory write follows the read by one cycle
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    pmRdEn |=> (dmWrEn && $stable(dmWrAddr)));

  // R7: the latch holds outside write cycles
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commitWrite |=> $stable(highLatch));

  // R11: the address is stable through the fetch and write cycles
  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pmRdEn |=> $stable(pmAddr));

endmodule

// File: rtl/pgtbl_reader.sv
module pgtbl_reader
  import pgtbl_pkg::*;
#(
  parameter int         PTR_W     = 8,
  parameter int         DM_AW     = 8,
  parameter logic [7:0] LAST_PAGE = 8'h9F,
  localparam int        ADDR_W    = 2 * PTR_W,
  localparam int        WORD_W    = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [PTR_W-1:0]  regWrData,
  input  logic [1:0]        regRdSel,
  output logic [PTR_W-1:0]  regRdData,
  input  logic              cmdValid,
  input  logic              cmdLast,
  input  logic [DM_AW-1:0]  cmdDest,
  output logic              pmRdEn,
  output logic [ADDR_W-1:0] pmAddr,
  input  logic [WORD_W-1:0] pmData,
  output logic              dmWrEn,
  output logic [DM_AW-1:0]  dmWrAddr,
  output logic [PTR_W-1:0]  dmWrData,
  output logic              stall,
  output logic              busy
);

  tblStrobe_t stb;

  pgtbl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdLast  (cmdLast),
    .stb      (stb),
    .busy     (busy),
    .stall    (stall)
  );

  pgtbl_dp #(
    .PTR_W     (PTR_W),
    .DM_AW     (DM_AW),
    .LAST_PAGE (LAST_PAGE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .regWrData (regWrData),
    .regRdSel  (regRdSel),
    .regRdData (regRdData),
    .cmdDest   (cmdDest),
    .pmRdEn    (pmRdEn),
    .pmAddr    (pmAddr),
    .pmData    (pmData),
    .dmWrEn    (dmWrEn),
    .dmWrAddr  (dmWrAddr),
    .dmWrData  (dmWrData)
  );

endmodule

// File: tb/sim_pgtbl_reader.sv
`timescale 1ns/1ps
module sim_pgtbl_reader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [1:0]  regRdSel = '0;
  logic [7:0]  regRdData;
  logic        cmdValid = 1'b0;
  logic        cmdLast = 1'b0;
  logic [7:0]  cmdDest = '0;
  logic        pmRdEn;
  logic [15:0] pmAddr;
  logic [15:0] pmData = '0;
  logic        dmWrEn;
  logic [7:0]  dmWrAddr;
  logic [7:0]  dmWrData;
  logic        stall;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int dmWrCount = 0;
  int pmRdCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgtbl_reader u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdLast(cmdLast), .cmdDest(cmdDest),
    .pmRdEn(pmRdEn), .pmAddr(pmAddr), .pmData(pmData),
    .dmWrEn(dmWrEn), .dmWrAddr(dmWrAddr), .dmWrData(dmWrData),
    .stall(stall), .busy(busy)
  );

  function automatic logic [15:0] romWord(input logic [15:0] a);
    logic [31:0] p;
    p = {16'h0, a} * 32'h9E37;
    return p[15:0] ^ 16'h1234;
  endfunction

  // Synchronous program memory, one cycle latency
  always @(posedge clk) if (pmRdEn) pmData <= romWord(pmAddr);

  always @(posedge clk) begin
    if (rstN && dmWrEn) dmWrCount++;
    if (rstN && pmRdEn) pmRdCount++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    regRdSel = sel;
    #0.1;
    val = regRdData;
  endtask

  // Issue one lookup and check both cycles and the latch
  task automatic lookup(input logic last, input logic [7:0] page, input logic [7:0] off,
                        input logic [7:0] dest);
    logic [15:0] addr;
    logic [15:0] w;
    logic [7:0]  rd;
    addr = {last ? 8'h9F : page, off};
    w = romWord(addr);
    writeReg(1'b0, off);
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = page;
    @(negedge clk);
    regWrEn = 1'b0;
    cmdValid = 1'b1; cmdLast = last; cmdDest = dest;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(pmAddr[7:0] == off, "R1 low addr", pmAddr[7:0], off);
    if (last) chk(pmAddr[15:8] == 8'h9F, "R3 last page", pmAddr[15:8], 8'h9F);
    else      chk(pmAddr[15:8] == page, "R2 page addr", pmAddr[15:8], page);
    chk(stall && pmRdEn && busy && !dmWrEn, "R8 fetch cycle",
        {stall, pmRdEn, busy, dmWrEn}, 4'b1110);
    @(negedge clk);
    chk(dmWrEn && !stall && busy && !pmRdEn, "R8 write cycle",
        {stall, pmRdEn, busy, dmWrEn}, 4'b0011);
    chk(dmWrAddr == dest, "R4 dest addr", dmWrAddr, dest);
    chk(dmWrData == w[7:0], "R4 low byte", dmWrData, w[7:0]);
    @(negedge clk);
    chk(!busy && !dmWrEn, "R8 idle after", {busy, dmWrEn}, 2'b00);
    readReg(2'd2, rd);
    chk(rd == w[15:8], "R5 high latch", rd, w[15:8]);
  endtask

  // {last, page, offset, dest}
  localparam logic [24:0] VECS [8] = '{
    {1'b0, 8'h00, 8'h00, 8'h01},
    {1'b0, 8'h12, 8'h34, 8'h02},
    {1'b0, 8'hFF, 8'hFF, 8'hFE},
    {1'b1, 8'h55, 8'hAA, 8'h40},
    {1'b1, 8'h00, 8'h01, 8'h41},
    {1'b0, 8'h9F, 8'h80, 8'h7F},
    {1'b1, 8'hA0, 8'h7F, 8'h80},
    {1'b0, 8'h01, 8'hFE, 8'hC3}
  };

  initial begin
    logic [7:0] rd;
    logic [7:0] held;
    logic [15:0] w;
    int dmBase;
    int pmBase;

    // R10: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !stall && !pmRdEn && !dmWrEn, "R10 outputs idle",
        {busy, stall, pmRdEn, dmWrEn}, 4'b0000);
    readReg(2'd0, rd); chk(rd == 8'h00, "R10 offset zero", rd, 8'h00);
    readReg(2'd1, rd); chk(rd == 8'h00, "R10 page zero", rd, 8'h00);
    readReg(2'd2, rd); chk(rd == 8'h00, "R10 latch zero", rd, 8'h00);

    // Vector walk: R1..R5, R8
    foreach (VECS[i]) lookup(VECS[i][24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0]);

    // R6: register read-back
    writeReg(1'b0, 8'h3C);
    writeReg(1'b1, 8'hC3);
    readReg(2'd0, rd); chk(rd == 8'h3C, "R6 offset readback", rd, 8'h3C);
    readReg(2'd1, rd); chk(rd == 8'hC3, "R6 page readback", rd, 8'hC3);
    readReg(2'd3, rd); chk(rd == 8'h00, "R6 unused select", rd, 8'h00);

    // R7: register writes leave the latch alone
    readReg(2'd2, held);
    writeReg(1'b0, ~held);
    writeReg(1'b1, 8'h5A);
    readReg(2'd2, rd); chk(rd == held, "R7 latch kept", rd, held);

    // R9: command held high through a lookup
    writeReg(1'b0, 8'h04);
    writeReg(1'b1, 8'h03);
    dmBase = dmWrCount; pmBase = pmRdCount;
    @(negedge clk);
    cmdValid = 1'b1; cmdLast = 1'b0; cmdDest = 8'h10;
    @(negedge clk);
    cmdDest = 8'h20;
    chk(busy, "R9 busy fetch", busy, 1);
    @(negedge clk);
    chk(busy, "R9 busy write", busy, 1);
    chk(dmWrAddr == 8'h10, "R9 dest unchanged", dmWrAddr, 8'h10);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    chk(dmWrCount - dmBase == 1, "R9 single dm write", dmWrCount - dmBase, 1);
    chk(pmRdCount - pmBase == 1, "R9 single pm read", pmRdCount - pmBase, 1);
    chk(!busy, "R9 idle after", busy, 0);

    // R11: register writes during a lookup
    writeReg(1'b0, 8'h21);
    writeReg(1'b1, 8'h43);
    w = romWord(16'h4321);
    @(negedge clk);
    cmdValid = 1'b1; cmdLast = 1'b0; cmdDest = 8'h05;
    @(negedge clk);
    cmdValid = 1'b0;
    regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 8'h77;
    @(negedge clk);
    regWrSel = 1'b1; regWrData = 8'h66;
    chk(pmAddr == 16'h4321, "R11 addr frozen", pmAddr, 16'h4321);
    chk(dmWrData == w[7:0], "R11 low byte", dmWrData, w[7:0]);
    @(negedge clk);
    regWrEn = 1'b0;
    readReg(2'd2, rd); chk(rd == w[15:8], "R11 high latch", rd, w[15:8]);
    readReg(2'd0, rd); chk(rd == 8'h77, "R11 offset written", rd, 8'h77);
    readReg(2'd1, rd); chk(rd == 8'h66, "R11 page written", rd, 8'h66);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule